// File: doc/BRIEF.md
# Narrow-to-Wide Registered Bus Exchanger

This block moves data in both directions between a narrow port A of `NW` bits (12 by default) and a wide port B of twice that width. Port B is handled as two halves: the low half (bits `NW-1:0`) and the high half (bits `2*NW-1:NW`). Going from A to B, two narrow words that arrive one after another on A are lined up and shown together as one wide word on B. Going from B to A, a wide word is captured from B and one of its two halves is steered onto A.

Every storage element loads on the rising clock edge. The data registers load only while their active-low load enable is low. The path from A into the low half of B has two register stages in series that share one enable; the path from A into the high half has a single stage with its own enable. The half select and both active-low output enables are sampled on every edge, so a change of selection or of bus direction appears only after a clock edge. The tri-state pads are represented by a data output plus an active-high drive-enable output per port.

Typical use for packing words W0 then W1 into one wide word with W0 in the low half and W1 in the high half: hold the low-half load enable low during the cycle W0 is on A and the cycle after, and hold the high-half load enable low only during the cycle W1 is on A.

Top module: `nw_bus_exchanger`

## Requirements
- R1: When `rst` is high at a rising edge, after that edge `a_out` and `b_out` are zero, the half select reads as low half, and both `a_oe` and `b_oe` are 0.
- R2: The path from `a_in` to `b_out[NW-1:0]` has two register stages, both loading on an edge where `ld_a_lo_n` is 0; after two such edges, `b_out[NW-1:0]` shows the `a_in` value captured at the first of them.
- R3: The path from `a_in` to `b_out[2*NW-1:NW]` has one register stage; after an edge where `ld_a_hi_n` is 0 it shows the `a_in` value present at that edge.
- R4: A register whose load enable is 1 at an edge keeps its value, whatever its data input does.
- R5: On an edge where `ld_b_lo_n` is 0 the B low-half register captures `b_in[NW-1:0]`; on an edge where `ld_b_hi_n` is 0 the B high-half register captures `b_in[2*NW-1:NW]`.
- R6: `sel_hi` is registered: after an edge with `sel_hi`=0, `a_out` shows the B low-half register; after an edge with `sel_hi`=1, it shows the B high-half register. A change of `sel_hi` between edges leaves `a_out` unchanged until the next edge.
- R7: `oe_a_n` and `oe_b_n` are registered: after each edge `a_oe` equals the inverse of `oe_a_n` and `b_oe` the inverse of `oe_b_n` as sampled at that edge, and a change between edges has no effect until the next edge.
- R8: Following the packing sequence above, `b_out` equals {W1, W0} after the second edge of the sequence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, active high |
| a_in | input | NW | Narrow port data sampled from the A pads |
| a_out | output | NW | Narrow port data driven toward the A pads |
| a_oe | output | 1 | Drive enable for the A pads, active high |
| b_in | input | 2*NW | Wide port data sampled from the B pads |
| b_out | output | 2*NW | Wide port data driven toward the B pads |
| b_oe | output | 1 | Drive enable for the B pads, active high |
| ld_a_lo_n | input | 1 | Active-low load enable of both A-to-low-half stages |
| ld_a_hi_n | input | 1 | Active-low load enable of the A-to-high-half stage |
| ld_b_lo_n | input | 1 | Active-low load enable of the B low-half capture |
| ld_b_hi_n | input | 1 | Active-low load enable of the B high-half capture |
| sel_hi | input | 1 | Half select for port A: 0 low half, 1 high half |
| oe_a_n | input | 1 | Active-low output enable request for port A |
| oe_b_n | input | 1 | Active-low output enable request for port B |

## Verification
The bench targets the unequal depth of the two A-to-B paths: loading only the low-half chain must shift the older word into the low half while the high half holds, and a design with one stage in that chain would show the newer word instead of the older one. It changes the half select and the output enables between edges and samples before the next edge, which exposes a design that routes them combinationally. It also changes `b_in` with both B load enables high and asserts reset in the middle of traffic with every load enable low, catching a capture that ignores its enable or a reset that loses to a load.

// File: rtl/nwx_pkg.sv
package nwx_pkg;

   localparam int unsigned NWX_DEFAULT_NW = 12;
   localparam int unsigned NWX_DEFAULT_LO_STAGES = 2;

   typedef enum logic {
      NWX_HALF_LO = 1'b0,
      NWX_HALF_HI = 1'b1
   } nwx_half_e;

endpackage

// File: rtl/nwx_a2b_path.sv
module nwx_a2b_path #(
   parameter int unsigned NW        = nwx_pkg::NWX_DEFAULT_NW,
   parameter int unsigned LO_STAGES = nwx_pkg::NWX_DEFAULT_LO_STAGES
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NW-1:0]   a_in,
   input  logic            ld_lo_n,
   input  logic            ld_hi_n,
   output logic [2*NW-1:0] wide_q
);

   localparam int unsigned WW = 2 * NW;

   generate
      if (NW < 1) begin : g_bad_nw
         $error("nwx_a2b_path: NW must be at least 1");
      end
      if (LO_STAGES < 1 || LO_STAGES > 8) begin : g_bad_depth
         $error("nwx_a2b_path: LO_STAGES must be 1 to 8");
      end
   endgenerate

   logic [NW-1:0] lo_stg [LO_STAGES];
   logic [NW-1:0] hi_q;

   generate
      for (genvar s = 0; s < LO_STAGES; s++) begin : g_lo_chain
         if (s == 0) begin : g_head
            always_ff @(posedge clk) begin
               if (rst) begin
                  lo_stg[0] <= '0;
               end else if (!ld_lo_n) begin
                  lo_stg[0] <= a_in;
               end
            end
         end else begin : g_tail
            always_ff @(posedge clk) begin
               if (rst) begin
                  lo_stg[s] <= '0;
               end else if (!ld_lo_n) begin
                  lo_stg[s] <= lo_stg[s-1];
               end
            end
            // R2: each later stage takes the previous one's value on a load
            p_lo_shift_r2: assert property (@(posedge clk) disable iff (rst)
               !ld_lo_n |=> lo_stg[s] == $past(lo_stg[s-1]));
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         hi_q <= '0;
      end else if (!ld_hi_n) begin
         hi_q <= a_in;
      end
   end

   assign wide_q = {hi_q, lo_stg[LO_STAGES-1]};

   // R2: the head stage captures the narrow input
   p_lo_head_r2: assert property (@(posedge clk) disable iff (rst)
      !ld_lo_n |=> lo_stg[0] == $past(a_in));

   // R3: high half captures the narrow input in one stage
   p_hi_load_r3: assert property (@(posedge clk) disable iff (rst)
      !ld_hi_n |=> wide_q[WW-1:NW] == $past(a_in));

   // R4: the low chain holds while its enable is high
   p_lo_hold_r4: assert property (@(posedge clk) disable iff (rst)
      ld_lo_n |=> $stable(wide_q[NW-1:0]));

   // R4: the high half holds while its enable is high
   p_hi_hold_r4: assert property (@(posedge clk) disable iff (rst)
      ld_hi_n |=> $stable(wide_q[WW-1:NW]));

endmodule

// File: rtl/nwx_b2a_path.sv
module nwx_b2a_path #(
   parameter int unsigned NW = nwx_pkg::NWX_DEFAULT_NW
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [2*NW-1:0] b_in,
   input  logic            ld_lo_n,
   input  logic            ld_hi_n,
   input  logic            sel_hi,
   output logic [NW-1:0]   narrow_q
);

   import nwx_pkg::*;

   localparam int unsigned WW = 2 * NW;

   generate
      if (NW < 1) begin : g_bad_nw
         $error("nwx_b2a_path: NW must be at least 1");
      end
   endgenerate

   logic [NW-1:0] half_q [2];
   logic [1:0]    half_ld_n;
   nwx_half_e     pick_q;

   assign half_ld_n = {ld_hi_n, ld_lo_n};

   generate
      for (genvar h = 0; h < 2; h++) begin : g_half
         always_ff @(posedge clk) begin
            if (rst) begin
               half_q[h] <= '0;
            end else if (!half_ld_n[h]) begin
               half_q[h] <= b_in[h*NW +: NW];
            end
         end
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (rst) begin
         pick_q <= NWX_HALF_LO;
      end else begin
         pick_q <= sel_hi ? NWX_HALF_HI : NWX_HALF_LO;
      end
   end

   always_comb begin
      unique case (pick_q)
         NWX_HALF_HI: narrow_q = half_q[1];
         default:     narrow_q = half_q[0];
      endcase
   end

   // R5 and R6: low half captured and selected shows on the narrow output
   p_lo_pass_r5: assert property (@(posedge clk) disable iff (rst)
      (!ld_lo_n && !sel_hi) |=> narrow_q == $past(b_in[NW-1:0]));

   // R5 and R6: high half captured and selected shows on the narrow output
   p_hi_pass_r6: assert property (@(posedge clk) disable iff (rst)
      (!ld_hi_n && sel_hi) |=> narrow_q == $past(b_in[WW-1:NW]));

   // R6: with no loads and a steady select the output holds
   p_sel_hold_r6: assert property (@(posedge clk) disable iff (rst)
      (ld_lo_n && ld_hi_n && $stable(sel_hi)) |=> $stable(narrow_q));

endmodule

// File: rtl/nwx_dir_ctrl.sv
module nwx_dir_ctrl (
   input  logic clk,
   input  logic rst,
   input  logic oe_a_n,
   input  logic oe_b_n,
   output logic a_drive,
   output logic b_drive
);

   always_ff @(posedge clk) begin
      if (rst) begin
         a_drive <= 1'b0;
         b_drive <= 1'b0;
      end else begin
         a_drive <= ~oe_a_n;
         b_drive <= ~oe_b_n;
      end
   end

   // R7: enables follow the sampled active-low requests one edge later
   p_a_enable_r7: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> a_drive == !$past(oe_a_n));

   p_b_enable_r7: assert property (@(posedge clk) disable iff (rst)
      1'b1 |=> b_drive == !$past(oe_b_n));

endmodule

// File: rtl/nw_bus_exchanger.sv
module nw_bus_exchanger #(
   parameter int unsigned NW        = nwx_pkg::NWX_DEFAULT_NW,
   parameter int unsigned LO_STAGES = nwx_pkg::NWX_DEFAULT_LO_STAGES
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [NW-1:0]   a_in,
   output logic [NW-1:0]   a_out,
   output logic            a_oe,
   input  logic [2*NW-1:0] b_in,
   output logic [2*NW-1:0] b_out,
   output logic            b_oe,
   input  logic            ld_a_lo_n,
   input  logic            ld_a_hi_n,
   input  logic            ld_b_lo_n,
   input  logic            ld_b_hi_n,
   input  logic            sel_hi,
   input  logic            oe_a_n,
   input  logic            oe_b_n
);

   generate
      if (NW < 1) begin : g_bad_nw
         $error("nw_bus_exchanger: NW must be at least 1");
      end
   endgenerate

   nwx_a2b_path #(
      .NW        (NW),
      .LO_STAGES (LO_STAGES)
   ) u_a2b (
      .clk     (clk),
      .rst     (rst),
      .a_in    (a_in),
      .ld_lo_n (ld_a_lo_n),
      .ld_hi_n (ld_a_hi_n),
      .wide_q  (b_out)
   );

   nwx_b2a_path #(
      .NW (NW)
   ) u_b2a (
      .clk      (clk),
      .rst      (rst),
      .b_in     (b_in),
      .ld_lo_n  (ld_b_lo_n),
      .ld_hi_n  (ld_b_hi_n),
      .sel_hi   (sel_hi),
      .narrow_q (a_out)
   );

   nwx_dir_ctrl u_dir (
      .clk     (clk),
      .rst     (rst),
      .oe_a_n  (oe_a_n),
      .oe_b_n  (oe_b_n),
      .a_drive (a_oe),
      .b_drive (b_oe)
   );

   // R1: reset wins over every load and clears the observable state
   p_reset_clear_r1: assert property (@(posedge clk)
      rst |=> (a_out == '0) && (b_out == '0) && !a_oe && !b_oe);

endmodule

// File: tb/nw_bus_exchanger_tb.sv
module nw_bus_exchanger_tb;

   localparam int NW = 12;

   logic            clk = 1'b0;
   logic            rst;
   logic [NW-1:0]   a_in;
   logic [NW-1:0]   a_out;
   logic            a_oe;
   logic [2*NW-1:0] b_in;
   logic [2*NW-1:0] b_out;
   logic            b_oe;
   logic            ld_a_lo_n, ld_a_hi_n, ld_b_lo_n, ld_b_hi_n;
   logic            sel_hi, oe_a_n, oe_b_n;

   int checks = 0;
   int errors = 0;
   bit done   = 1'b0;

   always #2.5 clk = ~clk;

   nw_bus_exchanger #(.NW(NW)) u_dut (
      .clk       (clk),
      .rst       (rst),
      .a_in      (a_in),
      .a_out     (a_out),
      .a_oe      (a_oe),
      .b_in      (b_in),
      .b_out     (b_out),
      .b_oe      (b_oe),
      .ld_a_lo_n (ld_a_lo_n),
      .ld_a_hi_n (ld_a_hi_n),
      .ld_b_lo_n (ld_b_lo_n),
      .ld_b_hi_n (ld_b_hi_n),
      .sel_hi    (sel_hi),
      .oe_a_n    (oe_a_n),
      .oe_b_n    (oe_b_n)
   );

   typedef struct packed {
      logic [11:0] a;
      logic [23:0] b;
      logic        la_lo_n, la_hi_n, lb_lo_n, lb_hi_n, sel, oea_n, oeb_n;
      logic [11:0] xa;
      logic [23:0] xb;
      logic        xaoe, xboe;
   } vec_t;

   // rows applied one per cycle after reset; expected values are after that row's edge
   localparam vec_t VEC [8] = '{
      '{12'h111, 24'h000000, 1'b0,1'b1,1'b1,1'b1, 1'b0,1'b1,1'b0, 12'h000, 24'h000000, 1'b0,1'b1},
      '{12'h222, 24'h000000, 1'b0,1'b0,1'b1,1'b1, 1'b0,1'b1,1'b0, 12'h000, 24'h222111, 1'b0,1'b1},
      '{12'h333, 24'hABC456, 1'b1,1'b1,1'b0,1'b1, 1'b0,1'b0,1'b1, 12'h456, 24'h222111, 1'b1,1'b0},
      '{12'h444, 24'hDEF789, 1'b1,1'b1,1'b1,1'b0, 1'b1,1'b0,1'b1, 12'hDEF, 24'h222111, 1'b1,1'b0},
      '{12'h444, 24'h000000, 1'b1,1'b1,1'b1,1'b1, 1'b0,1'b0,1'b1, 12'h456, 24'h222111, 1'b1,1'b0},
      '{12'h555, 24'h000000, 1'b0,1'b1,1'b1,1'b1, 1'b1,1'b1,1'b1, 12'hDEF, 24'h222222, 1'b0,1'b0},
      '{12'h666, 24'h000000, 1'b1,1'b0,1'b1,1'b1, 1'b1,1'b0,1'b0, 12'hDEF, 24'h666222, 1'b1,1'b1},
      '{12'h777, 24'h123ABC, 1'b0,1'b0,1'b0,1'b0, 1'b0,1'b0,1'b0, 12'hABC, 24'h777555, 1'b1,1'b1}
   };

   task automatic check(input string req, input string what,
                        input logic [23:0] act, input logic [23:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic finish_run();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   task automatic idle_inputs();
      a_in = '0; b_in = '0;
      ld_a_lo_n = 1'b1; ld_a_hi_n = 1'b1; ld_b_lo_n = 1'b1; ld_b_hi_n = 1'b1;
      sel_hi = 1'b0; oe_a_n = 1'b1; oe_b_n = 1'b1;
   endtask

   initial begin
      #100000;
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual running expected finished");
         finish_run();
      end
   end

   initial begin
      idle_inputs();
      rst = 1'b1;
      repeat (3) @(negedge clk);
      // R1: reset state
      check("R1", "a_out after reset", {12'h0, a_out}, 24'h0);
      check("R1", "b_out after reset", b_out, 24'h0);
      check("R1", "enables after reset", {22'h0, a_oe, b_oe}, 24'h0);
      rst = 1'b0;

      // table walk: R2 R3 R4 R5 R6 R7 R8
      for (int i = 0; i < 8; i++) begin
         a_in = VEC[i].a; b_in = VEC[i].b;
         ld_a_lo_n = VEC[i].la_lo_n; ld_a_hi_n = VEC[i].la_hi_n;
         ld_b_lo_n = VEC[i].lb_lo_n; ld_b_hi_n = VEC[i].lb_hi_n;
         sel_hi = VEC[i].sel; oe_a_n = VEC[i].oea_n; oe_b_n = VEC[i].oeb_n;
         @(negedge clk);
         check("R8/R2/R3/R4", $sformatf("row %0d b_out", i), b_out, VEC[i].xb);
         check("R5/R6/R4", $sformatf("row %0d a_out", i), {12'h0, a_out}, {12'h0, VEC[i].xa});
         check("R7", $sformatf("row %0d enables", i), {22'h0, a_oe, b_oe},
               {22'h0, VEC[i].xaoe, VEC[i].xboe});
      end

      // R6: select change between edges takes effect only at the edge
      idle_inputs();
      oe_a_n = 1'b0; oe_b_n = 1'b0;
      @(negedge clk);
      sel_hi = 1'b1;
      #1;
      check("R6", "a_out before edge", {12'h0, a_out}, 24'h000ABC);
      @(negedge clk);
      check("R6", "a_out after edge", {12'h0, a_out}, 24'h000123);

      // R7: enable request change between edges takes effect only at the edge
      oe_a_n = 1'b1;
      #1;
      check("R7", "a_oe before edge", {23'h0, a_oe}, 24'h1);
      @(negedge clk);
      check("R7", "a_oe after edge", {23'h0, a_oe}, 24'h0);
      check("R7", "b_oe steady", {23'h0, b_oe}, 24'h1);

      // R4: B input changes with B loads high do not reach a_out
      b_in = 24'hFFFFFF;
      sel_hi = 1'b0;
      @(negedge clk);
      check("R4", "low half held", {12'h0, a_out}, 24'h000ABC);

      // R2: a single loading edge leaves the old word in the low half
      a_in = 12'h9A5; ld_a_lo_n = 1'b0;
      @(negedge clk);
      check("R2", "low half one load later", b_out, 24'h777777);
      ld_a_lo_n = 1'b1; a_in = 12'h000;
      @(negedge clk);
      check("R2", "low half held between loads", b_out, 24'h777777);
      ld_a_lo_n = 1'b0;
      @(negedge clk);
      check("R2", "low half second load", b_out, 24'h7779A5);

      // R1: reset during traffic beats every load
      a_in = 12'hFFF; b_in = 24'hFFFFFF;
      ld_a_lo_n = 1'b0; ld_a_hi_n = 1'b0; ld_b_lo_n = 1'b0; ld_b_hi_n = 1'b0;
      sel_hi = 1'b1; oe_a_n = 1'b0; oe_b_n = 1'b0;
      rst = 1'b1;
      @(negedge clk);
      check("R1", "b_out reset mid-run", b_out, 24'h0);
      check("R1", "a_out reset mid-run", {12'h0, a_out}, 24'h0);
      check("R1", "enables reset mid-run", {22'h0, a_oe, b_oe}, 24'h0);
      rst = 1'b0;
      idle_inputs();

      // R1: select returns to low half after reset
      b_in = 24'h5A5C3C; ld_b_lo_n = 1'b0; ld_b_hi_n = 1'b0; sel_hi = 1'b0;
      @(negedge clk);
      check("R1", "select low after reset", {12'h0, a_out}, 24'h000C3C);

      done = 1'b1;
      finish_run();
   end

endmodule